// File: doc/BRIEF.md
# Rate-Capped Real-Time Slot Arbiter

This block shares one bus among four requesters and makes one ownership decision per bus slot. Requester 0 carries a latency-critical stream. It wins any slot where it asks and is eligible. Each time it wins, a cooldown takes it out of contention for the two slots that follow. Requesters 1, 2 and 3 are best-effort. They take every slot that requester 0 does not take, and they are served in rotating order so that none of them is locked out.

A one-cycle strobe marks the start of each slot. On that edge the block samples the four request lines and registers its decision as a one-hot grant vector, together with a valid flag. The grant is held until the next strobe. A monitor counts how many slots in a row requester 0 has asked and been refused. It raises a flag if that count ever reaches the latency bound.

Top module: `rt_slot_arbiter`

## Requirements
- R1: A synchronous active-low reset drives the grant vector, the valid flag and the late flag to zero. It clears the cooldown and points the rotation at requester 1.
- R2: When requester 0 asks in a slot and is not cooling down, the grant for that slot is 4'b0001, whatever the other requesters do.
- R3: After requester 0 wins a slot, it receives no grant in either of the next 2 slots, even when it is the only requester.
- R4: A slot that requester 0 does not win goes to the first best-effort requester that is asking. The search starts at the rotation pointer and runs 1, 2, 3 and wraps back to 1. After requester k wins, the pointer moves to the requester that follows k in that order.
- R5: A win by requester 0 leaves the rotation pointer unchanged.
- R6: Grant bit i (bit 0 = requester 0, bit 3 = requester 3) is the only position used for requester i. At most one grant bit is set. The valid flag is set exactly when a grant bit is set. A slot with no eligible request has an all-zero grant, including a slot where only a cooling requester 0 asks.
- R7: Slots with no grant still count down requester 0's cooldown.
- R8: Grants and cooldown change only on cycles where the slot strobe is high. Between strobes the grant is held and the cooldown does not advance.
- R9: A request from requester 0 that is held continuously is granted within 3 slots. The late flag goes high once requester 0 has been refused in 3 consecutive slots while asking, so on this design it stays low.
- R10: When all four requesters ask continuously, the steady grant order is 0,1,2,0,3,1,0,2,3 and it repeats. No more than 4 slots pass between two consecutive grants to requester 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_adv | input | 1 | Slot strobe; a decision is taken on this cycle |
| req | input | 4 | Request lines, bit i for requester i |
| grant | output | 4 | One-hot grant for the current slot |
| grant_vld | output | 1 | Set when some requester holds the slot |
| rt_late | output | 1 | Latency-bound violation flag for requester 0 |

## Verification
The hardest case to reach is the interaction between the cooldown and the rotation pointer. The bench must show that a win by requester 0 leaves the pointer exactly where it was. To do this it first moves the pointer to requester 3 with a lone win by requester 2. Next comes a lone win by requester 0. Last comes a slot where all three best-effort requesters ask, and that slot must go to requester 3. A second hard case is that cooldown counts slots and not clock cycles. To reach it, the bench holds the strobe low for many cycles right after a win by requester 0 and then checks that the cooldown is still fully in force.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NUM_REQ   = 4;
  localparam int NUM_BE    = NUM_REQ - 1;
  localparam int COOL_SLOTS = 2;
  localparam int LAT_BOUND = 3;
  localparam int PTR_W     = $clog2(NUM_BE);

  // First asserted best-effort request at or after position ptr, one-hot.
  function automatic logic [NUM_BE-1:0] rr_pick(input logic [NUM_BE-1:0] be_req,
                                               input logic [PTR_W-1:0] ptr);
    logic [NUM_BE-1:0] sel;
    logic              found;
    int                idx;
    sel   = '0;
    found = 1'b0;
    for (int k = 0; k < NUM_BE; k++) begin
      idx = (int'(ptr) + k) % NUM_BE;
      if (!found && be_req[idx]) begin
        sel[idx] = 1'b1;
        found    = 1'b1;
      end
    end
    return sel;
  endfunction

  // Position that follows the granted one, wrapping.
  function automatic logic [PTR_W-1:0] rr_next(input logic [NUM_BE-1:0] sel,
                                              input logic [PTR_W-1:0] ptr);
    logic [PTR_W-1:0] nxt;
    nxt = ptr;
    for (int k = 0; k < NUM_BE; k++)
      if (sel[k]) nxt = PTR_W'((k + 1) % NUM_BE);
    return nxt;
  endfunction
endpackage

// File: rtl/rt_cooldown.sv
module rt_cooldown #(
  parameter int COOL = arb_pkg::COOL_SLOTS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic win0,
  output logic elig
);
  localparam int CW = (COOL > 0) ? $clog2(COOL + 1) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (adv) begin
      if (win0)              cnt <= CW'(COOL);
      else if (cnt != '0)    cnt <= cnt - 1'b1;
    end
  end

  assign elig = (cnt == '0);

  // R3: no win is possible while the counter is running
  a_r3_no_win_cooling: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && win0) |-> elig);
endmodule

// File: rtl/be_rotator.sv
module be_rotator
  import arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              take,
  input  logic [NUM_BE-1:0] be_req,
  output logic [NUM_BE-1:0] pick
);
  logic [PTR_W-1:0] ptr;

  assign pick = take ? rr_pick(be_req, ptr) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)                  ptr <= '0;
    else if (adv && (|pick))     ptr <= rr_next(pick, ptr);
  end

  // R4: the choice is never more than one requester
  a_r4_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick));
  // R4: an asserted request is never skipped when the rotator may take the slot
  a_r4_no_idle_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (|be_req)) |-> (|pick));
endmodule

// File: rtl/rt_wait_mon.sv
module rt_wait_mon #(
  parameter int BOUND = arb_pkg::LAT_BOUND
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic rt_req,
  input  logic rt_won,
  output logic late
);
  localparam int WW = $clog2(BOUND + 1);
  logic [WW-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                   wcnt <= '0;
    else if (adv) begin
      if (rt_req && !rt_won) begin
        if (wcnt != WW'(BOUND))   wcnt <= wcnt + 1'b1;
      end else                    wcnt <= '0;
    end
  end

  assign late = (wcnt >= WW'(BOUND));

  // R9: the real-time requester never reaches the refusal bound
  a_r9_latency_bound: assert property (@(posedge clk) disable iff (!rst_n) !late);
endmodule

// File: rtl/rt_slot_arbiter.sv
module rt_slot_arbiter
  import arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slot_adv,
  input  logic [NUM_REQ-1:0] req,
  output logic [NUM_REQ-1:0] grant,
  output logic               grant_vld,
  output logic               rt_late
);
  logic              rt_elig;
  logic              rt_win;
  logic [NUM_BE-1:0] be_pick;
  logic [NUM_REQ-1:0] grant_nxt;

  assign rt_win = req[0] & rt_elig;

  rt_cooldown #(.COOL(COOL_SLOTS)) u_cool (
    .clk(clk), .rst_n(rst_n), .adv(slot_adv), .win0(rt_win), .elig(rt_elig)
  );

  be_rotator u_rr (
    .clk(clk), .rst_n(rst_n), .adv(slot_adv), .take(!rt_win),
    .be_req(req[NUM_REQ-1:1]), .pick(be_pick)
  );

  rt_wait_mon #(.BOUND(LAT_BOUND)) u_mon (
    .clk(clk), .rst_n(rst_n), .adv(slot_adv), .rt_req(req[0]),
    .rt_won(rt_win), .late(rt_late)
  );

  always_comb begin
    if (rt_win) grant_nxt = NUM_REQ'(1);
    else        grant_nxt = {be_pick, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        grant <= '0;
    else if (slot_adv) grant <= grant_nxt;
  end

  assign grant_vld = |grant;

  // R6: never more than one owner
  a_r6_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R2: an eligible real-time request owns the next slot
  a_r2_rt_first: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_adv && req[0] && rt_elig) |=> grant[0]);
  // R3: no back-to-back real-time slots
  a_r3_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_adv && grant[0]) |=> !grant[0]);
  // R8: grant held between strobes
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_adv && rst_n) |=> $stable(grant));
endmodule

// File: tb/tb_rt_slot_arbiter.sv
module tb_rt_slot_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slot_adv = 1'b0;
  logic [3:0] req = 4'b0;
  logic [3:0] grant;
  logic       grant_vld;
  logic       rt_late;

  int checks = 0;
  int errors = 0;
  logic [3:0] g;

  always #5 clk = ~clk;

  rt_slot_arbiter dut (
    .clk(clk), .rst_n(rst_n), .slot_adv(slot_adv), .req(req),
    .grant(grant), .grant_vld(grant_vld), .rt_late(rt_late)
  );

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; slot_adv = 1'b0; req = 4'b0;
    repeat (3) @(negedge clk);
    chk("R1 grant at reset", grant, 4'b0);
    chk("R1 valid at reset", {3'b0, grant_vld}, 4'b0);
    chk("R1 late at reset", {3'b0, rt_late}, 4'b0);
    rst_n = 1'b1;
  endtask

  // one slot: strobe for one cycle, sample after the edge
  task automatic slot(input logic [3:0] r);
    @(negedge clk);
    req = r; slot_adv = 1'b1;
    @(negedge clk);
    slot_adv = 1'b0;
    g = grant;
    chk("R6 valid flag", {3'b0, grant_vld}, {3'b0, |g});
    chk("R6 at most one bit", {3'b0, ($countones(g) > 1)}, 4'b0);
    chk("R9 late flag", {3'b0, rt_late}, 4'b0);
  endtask

  task automatic t_cooldown();
    do_reset();
    slot(4'b1111); chk("R2 rt wins over all", g, 4'b0001);
    do_reset();
    slot(4'b0001); chk("R2 lone rt", g, 4'b0001);
    slot(4'b0001); chk("R3 cooling slot 1", g, 4'b0000);
    slot(4'b0001); chk("R3 cooling slot 2", g, 4'b0000);
    slot(4'b0001); chk("R9 rt back within bound", g, 4'b0001);
    slot(4'b0000); chk("R7 idle slot", g, 4'b0000);
    slot(4'b0000); chk("R7 idle slot", g, 4'b0000);
    slot(4'b0001); chk("R7 idle slots consumed cooldown", g, 4'b0001);
  endtask

  task automatic t_rotation();
    do_reset();
    slot(4'b1110); chk("R4 first from r1", g, 4'b0010);
    slot(4'b1110); chk("R4 then r2", g, 4'b0100);
    slot(4'b1110); chk("R4 then r3", g, 4'b1000);
    slot(4'b1110); chk("R4 wrap to r1", g, 4'b0010);
    slot(4'b1010); chk("R4 skip idle r2", g, 4'b1000);
    slot(4'b1010); chk("R4 wrap past r3", g, 4'b0010);
    slot(4'b1010); chk("R4 r3 again", g, 4'b1000);
  endtask

  task automatic t_pointer_hold();
    do_reset();
    slot(4'b0100); chk("R4 lone r2", g, 4'b0100);
    slot(4'b0001); chk("R2 rt between", g, 4'b0001);
    slot(4'b1110); chk("R5 pointer kept at r3", g, 4'b1000);
  endtask

  task automatic t_strobe_gating();
    do_reset();
    slot(4'b0001); chk("R2 rt win", g, 4'b0001);
    @(negedge clk);
    req = 4'b1110;
    repeat (10) @(negedge clk);
    chk("R8 grant held without strobe", grant, 4'b0001);
    slot(4'b0001); chk("R8 cooldown not spent by cycles", g, 4'b0000);
    slot(4'b0001); chk("R8 cooldown second slot", g, 4'b0000);
    slot(4'b0001); chk("R8 rt eligible again", g, 4'b0001);
  endtask

  task automatic t_all_busy();
    logic [3:0] exp_seq [18];
    int last3;
    int maxgap;
    for (int i = 0; i < 18; i++)
      case (i % 9)
        0, 3, 6: exp_seq[i] = 4'b0001;
        1, 5:    exp_seq[i] = 4'b0010;
        2, 7:    exp_seq[i] = 4'b0100;
        default: exp_seq[i] = 4'b1000;
      endcase
    do_reset();
    last3 = -1; maxgap = 0;
    for (int i = 0; i < 18; i++) begin
      slot(4'b1111);
      chk("R10 full-load order", g, exp_seq[i]);
      if (g[3]) begin
        if (last3 >= 0 && (i - last3 - 1) > maxgap) maxgap = i - last3 - 1;
        last3 = i;
      end
    end
    checks++;
    if (maxgap > 4 || last3 < 0) begin
      errors++;
      $display("FAIL R10 r3 gap: got %0d expected <= 4", maxgap);
    end
  endtask

  task automatic t_mid_reset();
    do_reset();
    slot(4'b0001);
    slot(4'b0100);
    do_reset();
    slot(4'b1111); chk("R1 cooldown cleared", g, 4'b0001);
    slot(4'b1110); chk("R1 pointer at r1", g, 4'b0010);
  endtask

  initial begin
    t_cooldown();
    t_rotation();
    t_pointer_hold();
    t_strobe_gating();
    t_all_busy();
    t_mid_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule